// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns the internal reset requests of a small microcontroller into one reset sequence. Four sources can start a sequence: a watchdog overflow, an illegal opcode (including a STOP executed while stop mode is disabled), an opcode fetch from an unmapped address, and a low-voltage detector. An accepted request does three things. It pulls the external reset pin low for a long count of reference-clock cycles. It keeps the CPU in reset for a short tail after that count. It records the source in a sticky status register.

Requests are sampled on the reference clock, and each source acts on its rising edge. The low-voltage input is the exception: while it stays asserted, the count is held at its start. A request that arrives during a running sequence restarts the count. Reading the status register clears it. The block also decides when the watchdog may be disabled: only in monitor mode or a break state, and only when a reset or interrupt pin is at the test high-voltage level.

Top module: `reset_sequencer`

## Requirements
- R1: A rising edge on `wdog_ovf_i` starts a reset sequence and sets status bit 1.
- R2: A rising edge on `ill_op_i` starts a reset sequence and sets status bit 2.
- R3: `stop_exec_i` rising while `stop_en_i` is 0 behaves as an illegal opcode (sequence plus status bit 2). While `stop_en_i` is 1, `stop_exec_i` starts no sequence and sets no flag.
- R4: `unmapped_i` starts a sequence and sets status bit 3 only when `opfetch_i` is high in the same cycle. An unmapped access with `opfetch_i` low starts no sequence and sets no flag.
- R5: A rising edge on `lowv_i` sets status bit 4. While `lowv_i` stays high, the count is held at zero, so the pin stays pulled for LONG_CYC cycles after the last cycle in which `lowv_i` was high.
- R6: After the last accepted request, `pin_pull_o` stays high for exactly LONG_CYC reference-clock cycles.
- R7: `cpu_rst_o` is high whenever `pin_pull_o` is high. It stays high for TAIL_CYC further cycles after the pin is released, then falls.
- R8: A request during a running sequence (pin phase or tail) restarts the count from zero. Its flag is added to the flags already set.
- R9: Status flags are sticky. A cycle with `rd_stb_i` high clears all of them, except a flag whose request arrives in that same cycle, which remains set.
- R10: Power-on reset (`por_n` low) sets the status to bit 0 only and starts a full sequence of LONG_CYC + TAIL_CYC cycles.
- R11: `wdog_dis_o` is high exactly when (`monitor_i` and (`hv_rst_i` or `hv_irq_i`)) or (`brk_i` and `hv_rst_i`).
- R12: Status encoding on `rd_data_o`: bit 0 power-on, bit 1 watchdog, bit 2 illegal opcode, bit 3 unmapped fetch, bit 4 low voltage. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdog_ovf_i | input | 1 | Watchdog overflow request |
| ill_op_i | input | 1 | Illegal instruction indication from the CPU |
| stop_exec_i | input | 1 | STOP instruction being executed |
| stop_en_i | input | 1 | Stop-mode enable option bit |
| unmapped_i | input | 1 | Access to an unmapped address |
| opfetch_i | input | 1 | Current access is an opcode fetch |
| lowv_i | input | 1 | Low-voltage indication |
| monitor_i | input | 1 | Chip is in monitor mode |
| brk_i | input | 1 | Chip is in a break state |
| hv_rst_i | input | 1 | Reset pin at the test high-voltage level |
| hv_irq_i | input | 1 | Interrupt pin at the test high-voltage level |
| rd_stb_i | input | 1 | Status read strobe; clears the flags |
| rd_data_o | output | STAT_W | Status register value |
| pin_pull_o | output | 1 | Active-high pull-down enable for the external reset pin |
| cpu_rst_o | output | 1 | Active-high CPU reset |
| wdog_dis_o | output | 1 | Watchdog disable qualifier |

## Verification
Two pairs of events can fall in the same cycle. A status read can coincide with a new request. The bench sets an older flag, then raises the read strobe and a watchdog request on the same edge. It expects the old flag gone and the new flag present. A restart can also coincide with any phase of a running count. The bench sweeps a second request across every cycle offset of the pin phase and the tail. It computes the expected pin-low and CPU-reset lengths from the offset and compares them with the counted lengths.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LONG = 2'd1,
      SEQ_TAIL = 2'd2
   } seq_state_e;

   // request lanes after qualification
   localparam int REQ_N    = 4;
   localparam int REQ_WDOG = 0;
   localparam int REQ_ILOP = 1;
   localparam int REQ_IADR = 2;
   localparam int REQ_LOWV = 3;

   // status bit positions
   localparam int FLG_N    = REQ_N + 1;
   localparam int FLG_POR  = 0;

endpackage

// File: rtl/rstseq_req_qual.sv
module rstseq_req_qual
   import rstseq_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wdog_ovf_i,
   input  logic             ill_op_i,
   input  logic             stop_exec_i,
   input  logic             stop_en_i,
   input  logic             unmapped_i,
   input  logic             opfetch_i,
   input  logic             lowv_i,
   output logic [REQ_N-1:0] evt_o,
   output logic             lowv_lvl_o
);

   logic [REQ_N-1:0] qual;
   logic [REQ_N-1:0] qual_s;
   logic [REQ_N-1:0] qual_d;

   always_comb begin
      qual           = '0;
      qual[REQ_WDOG] = wdog_ovf_i;
      qual[REQ_ILOP] = ill_op_i | (stop_exec_i & ~stop_en_i);
      qual[REQ_IADR] = unmapped_i & opfetch_i;
      qual[REQ_LOWV] = lowv_i;
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign qual_s = qual;
   end else begin : g_sync
      logic [REQ_N-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= qual;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign qual_s = chain[SYNC_STAGES-1];
   end

   for (genvar g = 0; g < REQ_N; g++) begin : g_edge
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) qual_d[g] <= 1'b0;
         else        qual_d[g] <= qual_s[g];
      end
      assign evt_o[g] = qual_s[g] & ~qual_d[g];
   end

   assign lowv_lvl_o = qual_s[REQ_LOWV];

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
   import rstseq_pkg::*;
#(
   parameter int LONG_CYC = 4128,
   parameter int TAIL_CYC = 32
) (
   input  logic clk,
   input  logic por_n,
   input  logic start_i,
   input  logic hold_i,
   output logic pin_pull_o,
   output logic cpu_rst_o
);

   localparam int MAX_CYC = (LONG_CYC > TAIL_CYC) ? LONG_CYC : TAIL_CYC;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

   seq_state_e       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state <= SEQ_LONG;
         cnt   <= '0;
      end else if (start_i || hold_i) begin
         state <= SEQ_LONG;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_LONG: begin
               if (cnt == LONG_LAST) begin
                  state <= SEQ_TAIL;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_TAIL: begin
               if (cnt == TAIL_LAST) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= SEQ_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign pin_pull_o = (state == SEQ_LONG);
   assign cpu_rst_o  = (state != SEQ_IDLE);

endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
   import rstseq_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [REQ_N-1:0]  evt_i,
   input  logic              rd_stb_i,
   output logic [STAT_W-1:0] rd_data_o
);

   logic [FLG_N-1:0] flags;
   logic [FLG_N-1:0] flags_nxt;

   always_comb begin
      flags_nxt = rd_stb_i ? '0 : flags;
      flags_nxt = flags_nxt | {evt_i, 1'b0};
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) flags <= FLG_N'(1) << FLG_POR;
      else        flags <= flags_nxt;
   end

   if (STAT_W > FLG_N) begin : g_pad
      assign rd_data_o = {{(STAT_W-FLG_N){1'b0}}, flags};
   end else begin : g_exact
      assign rd_data_o = flags;
   end

endmodule

// File: rtl/rstseq_wdog_gate.sv
module rstseq_wdog_gate (
   input  logic monitor_i,
   input  logic brk_i,
   input  logic hv_rst_i,
   input  logic hv_irq_i,
   output logic wdog_dis_o
);

   logic mon_path;
   logic brk_path;

   assign mon_path   = monitor_i & (hv_rst_i | hv_irq_i);
   assign brk_path   = brk_i & hv_rst_i;
   assign wdog_dis_o = mon_path | brk_path;

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
   import rstseq_pkg::*;
#(
   parameter int LONG_CYC    = 4096 + 32,
   parameter int TAIL_CYC    = 32,
   parameter int SYNC_STAGES = 0,
   parameter int STAT_W      = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wdog_ovf_i,
   input  logic              ill_op_i,
   input  logic              stop_exec_i,
   input  logic              stop_en_i,
   input  logic              unmapped_i,
   input  logic              opfetch_i,
   input  logic              lowv_i,
   input  logic              monitor_i,
   input  logic              brk_i,
   input  logic              hv_rst_i,
   input  logic              hv_irq_i,
   input  logic              rd_stb_i,
   output logic [STAT_W-1:0] rd_data_o,
   output logic              pin_pull_o,
   output logic              cpu_rst_o,
   output logic              wdog_dis_o
);

   if (LONG_CYC < 2) begin : g_bad_long
      $error("reset_sequencer: LONG_CYC must be at least 2");
   end
   if (TAIL_CYC < 1) begin : g_bad_tail
      $error("reset_sequencer: TAIL_CYC must be at least 1");
   end
   if (STAT_W < FLG_N) begin : g_bad_stat
      $error("reset_sequencer: STAT_W too narrow for the flags");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("reset_sequencer: SYNC_STAGES must be 0..3");
   end

   logic [REQ_N-1:0] evt;
   logic             lowv_lvl;

   rstseq_req_qual #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_qual (
      .clk         (clk),
      .por_n       (por_n),
      .wdog_ovf_i  (wdog_ovf_i),
      .ill_op_i    (ill_op_i),
      .stop_exec_i (stop_exec_i),
      .stop_en_i   (stop_en_i),
      .unmapped_i  (unmapped_i),
      .opfetch_i   (opfetch_i),
      .lowv_i      (lowv_i),
      .evt_o       (evt),
      .lowv_lvl_o  (lowv_lvl)
   );

   rstseq_timer #(
      .LONG_CYC (LONG_CYC),
      .TAIL_CYC (TAIL_CYC)
   ) u_timer (
      .clk        (clk),
      .por_n      (por_n),
      .start_i    (|evt),
      .hold_i     (lowv_lvl),
      .pin_pull_o (pin_pull_o),
      .cpu_rst_o  (cpu_rst_o)
   );

   rstseq_flags #(
      .STAT_W (STAT_W)
   ) u_flags (
      .clk       (clk),
      .por_n     (por_n),
      .evt_i     (evt),
      .rd_stb_i  (rd_stb_i),
      .rd_data_o (rd_data_o)
   );

   rstseq_wdog_gate u_wgate (
      .monitor_i  (monitor_i),
      .brk_i      (brk_i),
      .hv_rst_i   (hv_rst_i),
      .hv_irq_i   (hv_irq_i),
      .wdog_dis_o (wdog_dis_o)
   );

endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk #(
   parameter int SYNC_STAGES = 0,
   parameter int STAT_W      = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic              wdog_ovf_i,
   input logic              ill_op_i,
   input logic              stop_exec_i,
   input logic              opfetch_i,
   input logic              lowv_i,
   input logic              monitor_i,
   input logic              brk_i,
   input logic              hv_rst_i,
   input logic              hv_irq_i,
   input logic              rd_stb_i,
   input logic [STAT_W-1:0] rd_data_o,
   input logic              pin_pull_o,
   input logic              cpu_rst_o,
   input logic              wdog_dis_o
);

   p_pin_under_cpu_r7: assert property (@(posedge clk) disable iff (!por_n)
      pin_pull_o |-> cpu_rst_o);

   p_tail_after_pin_r7: assert property (@(posedge clk) disable iff (!por_n)
      $fell(pin_pull_o) |-> cpu_rst_o);

   p_release_from_tail_r7: assert property (@(posedge clk) disable iff (!por_n)
      $fell(cpu_rst_o) |-> !$past(pin_pull_o));

   p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      !$past(rd_stb_i) |-> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

   p_wdog_dis_mode_r11: assert property (@(posedge clk) disable iff (!por_n)
      (!monitor_i && !brk_i) |-> !wdog_dis_o);

   p_wdog_dis_hv_r11: assert property (@(posedge clk) disable iff (!por_n)
      (!hv_rst_i && !hv_irq_i) |-> !wdog_dis_o);

   if (SYNC_STAGES == 0) begin : g_direct
      p_quiet_stays_idle_r4: assert property (@(posedge clk) disable iff (!por_n)
         (!cpu_rst_o && !opfetch_i && !wdog_ovf_i && !ill_op_i && !stop_exec_i && !lowv_i)
         |=> !cpu_rst_o);

      p_lowv_holds_pin_r5: assert property (@(posedge clk) disable iff (!por_n)
         lowv_i |=> pin_pull_o);

      p_read_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
         (rd_stb_i && !wdog_ovf_i && !ill_op_i && !stop_exec_i && !opfetch_i && !lowv_i)
         |=> (rd_data_o == '0));
   end

endmodule

bind reset_sequencer reset_sequencer_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .STAT_W      (STAT_W)
) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .wdog_ovf_i  (wdog_ovf_i),
   .ill_op_i    (ill_op_i),
   .stop_exec_i (stop_exec_i),
   .opfetch_i   (opfetch_i),
   .lowv_i      (lowv_i),
   .monitor_i   (monitor_i),
   .brk_i       (brk_i),
   .hv_rst_i    (hv_rst_i),
   .hv_irq_i    (hv_irq_i),
   .rd_stb_i    (rd_stb_i),
   .rd_data_o   (rd_data_o),
   .pin_pull_o  (pin_pull_o),
   .cpu_rst_o   (cpu_rst_o),
   .wdog_dis_o  (wdog_dis_o)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;

   localparam int LONG = 12;
   localparam int TAIL = 3;
   localparam int SW   = 8;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic wdog_ovf_i = 0, ill_op_i = 0, stop_exec_i = 0, stop_en_i = 0;
   logic unmapped_i = 0, opfetch_i = 0, lowv_i = 0;
   logic monitor_i = 0, brk_i = 0, hv_rst_i = 0, hv_irq_i = 0, rd_stb_i = 0;
   logic [SW-1:0] rd_data_o;
   logic pin_pull_o, cpu_rst_o, wdog_dis_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   reset_sequencer #(
      .LONG_CYC (LONG), .TAIL_CYC (TAIL), .SYNC_STAGES (0), .STAT_W (SW)
   ) u_reset_sequencer (
      .clk (clk), .por_n (por_n), .wdog_ovf_i (wdog_ovf_i), .ill_op_i (ill_op_i),
      .stop_exec_i (stop_exec_i), .stop_en_i (stop_en_i), .unmapped_i (unmapped_i),
      .opfetch_i (opfetch_i), .lowv_i (lowv_i), .monitor_i (monitor_i), .brk_i (brk_i),
      .hv_rst_i (hv_rst_i), .hv_irq_i (hv_irq_i), .rd_stb_i (rd_stb_i),
      .rd_data_o (rd_data_o), .pin_pull_o (pin_pull_o), .cpu_rst_o (cpu_rst_o),
      .wdog_dis_o (wdog_dis_o)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // source codes: 0 watchdog, 1 illegal op, 2 STOP while disabled,
   // 3 unmapped opcode fetch, 4 low voltage
   task automatic drive_src(int s, logic v);
      case (s)
         0: wdog_ovf_i  = v;
         1: ill_op_i    = v;
         2: stop_exec_i = v;
         3: begin unmapped_i = v; opfetch_i = v; end
         default: lowv_i = v;
      endcase
   endtask

   function automatic int flag_of(int s);
      case (s)
         0: return 2;
         1, 2: return 4;
         3: return 8;
         default: return 16;
      endcase
   endfunction

   // caller stands on a negedge with the block idle
   task automatic run_case(int s, int r, int j, int hold, output int pins, output int cpus);
      pins = 0; cpus = 0;
      drive_src(s, 1'b1);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == hold - 1) drive_src(s, 1'b0);
         if (r >= 0 && i == j)     drive_src(r, 1'b1);
         if (r >= 0 && i == j + 1) drive_src(r, 1'b0);
         if (pin_pull_o) pins++;
         if (cpu_rst_o)  cpus++;
         if (!cpu_rst_o) break;
      end
   endtask

   task automatic read_clear(string req, int exp);
      chk(req, int'(rd_data_o), exp);
      rd_stb_i = 1'b1;
      @(negedge clk);
      rd_stb_i = 1'b0;
      chk(req, int'(rd_data_o), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int pins, cpus;
      repeat (3) @(negedge clk);
      // R10 R12: reset state
      chk("R10 status", int'(rd_data_o), 1);
      chk("R10 pin", int'(pin_pull_o), 1);
      chk("R10 cpu", int'(cpu_rst_o), 1);
      por_n = 1'b1;
      pins = 0; cpus = 0;
      for (int i = 0; i < 400; i++) begin
         if (pin_pull_o) pins++;
         if (cpu_rst_o) cpus++;
         if (!cpu_rst_o) break;
         @(negedge clk);
      end
      chk("R10 pin length", pins, LONG);
      chk("R10 cpu length", cpus, LONG + TAIL);
      read_clear("R10 R12 por flag", 1);

      // R1 R2 R3 R4 R5 R6 R7: single request per source
      for (int s = 0; s < 5; s++) begin
         run_case(s, -1, 0, 1, pins, cpus);
         chk($sformatf("R6 pin length src%0d", s), pins, LONG);
         chk($sformatf("R7 cpu length src%0d", s), cpus, LONG + TAIL);
         read_clear($sformatf("R1 R2 R3 R4 R5 R12 flag src%0d", s), flag_of(s));
      end

      // R5: low voltage held for several cycles
      for (int h = 2; h <= 6; h++) begin
         run_case(4, -1, 0, h, pins, cpus);
         chk($sformatf("R5 hold %0d pin", h), pins, LONG + h - 1);
         chk($sformatf("R5 hold %0d cpu", h), cpus, LONG + TAIL + h - 1);
         read_clear("R5 flag", 16);
      end

      // R8: retrigger swept across every offset of pin phase and tail
      for (int s = 0; s < 5; s++) begin
         for (int j = 1; j < LONG + TAIL; j++) begin
            int r;
            r = (s + 1) % 5;
            run_case(s, r, j, 1, pins, cpus);
            chk($sformatf("R8 src%0d off%0d pin", s, j), pins,
                (j < LONG) ? (j + 1 + LONG) : (2 * LONG));
            chk($sformatf("R8 src%0d off%0d cpu", s, j), cpus, j + 1 + LONG + TAIL);
            read_clear("R8 flags", flag_of(s) | flag_of(r));
         end
      end

      // R3: STOP ignored while stop enabled
      stop_en_i = 1'b1;
      stop_exec_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R3 stop enabled cpu", int'(cpu_rst_o), 0);
      end
      stop_exec_i = 1'b0;
      @(negedge clk);
      chk("R3 stop enabled flags", int'(rd_data_o), 0);
      stop_en_i = 1'b0;

      // R4: data access to unmapped address ignored
      unmapped_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R4 data access cpu", int'(cpu_rst_o), 0);
      end
      unmapped_i = 1'b0;
      @(negedge clk);
      chk("R4 data access flags", int'(rd_data_o), 0);

      // R9: read strobe and new request in the same cycle
      run_case(1, -1, 0, 1, pins, cpus);
      chk("R9 prior flag", int'(rd_data_o), 4);
      rd_stb_i = 1'b1;
      wdog_ovf_i = 1'b1;
      @(negedge clk);
      rd_stb_i = 1'b0;
      wdog_ovf_i = 1'b0;
      chk("R9 read plus request", int'(rd_data_o), 2);
      for (int i = 0; i < 400 && cpu_rst_o; i++) @(negedge clk);
      // R9: flags sticky without a read
      chk("R9 sticky", int'(rd_data_o), 2);
      read_clear("R9 clear", 2);

      // R11: exhaustive sweep of the disable qualifier
      for (int v = 0; v < 16; v++) begin
         bit m, b, hr, hi;
         {m, b, hr, hi} = 4'(v);
         monitor_i = m; brk_i = b; hv_rst_i = hr; hv_irq_i = hi;
         @(negedge clk);
         chk($sformatf("R11 combo %0d", v), int'(wdog_dis_o),
             int'((m & (hr | hi)) | (b & hr)));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule